// File: doc/BRIEF.md
# Clock Source and Power-Mode Controller

This block decides which oscillator drives the system clock and keeps track of four operating modes: Normal, Slow, Idle and Sleep. All clocks are modelled as one-cycle enable pulses (ticks) within a single reference clock domain. Three tick inputs stand for the high-speed oscillator, the low-speed crystal and the internal low-speed RC. The block passes the selected tick on as `sys_ce` and drives an enable for each oscillator. It also produces a watchdog tick, taken from the system tick divided by four or from one of the two low-speed sources.

The state machine has six states. ST_NORMAL runs from the high-speed source. ST_SLOW runs from the low-speed crystal. ST_SWITCH is the drain state between the two sources: no system tick leaves the block until the first tick of the new source has arrived. ST_IDLE is the halt state in which the crystal keeps running. ST_SLEEP is the halt state in which the crystal is stopped. ST_WAKE is a stabilisation delay of `WAKE_CYCLES` cycles.

The transitions are as follows:
- NORMAL to SWITCH when slow is requested and allowed; SLOW to SWITCH when that request or permission goes away.
- SWITCH to its destination on that destination's first tick.
- NORMAL or SLOW to IDLE or SLEEP on a halt request.
- IDLE or SLEEP to WAKE on a wake event.
- WAKE to the mode held before the halt once the count ends.

Halt requests that arrive during SWITCH or WAKE are not acted on. The `FLEXIBLE` parameter picks between two variants. In the restricted variant the crystal is usable only with the internal high-speed RC, and it always runs through halt. In the flexible variant the crystal pairs with any high-speed source, and an enable bit decides whether it runs during halt.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset, `mode` is 2'b00 (Normal) and `hs_osc_en` is 1. In Normal, `sys_ce` pulses exactly on the cycles where `hs_tick` pulses.
- R2: With `hs_src`=0 (internal RC), `lx_fitted`=1 and `slow_sel`=1, the block settles in `mode` 2'b01 (Slow). There `sys_ce` pulses exactly with `lx_tick` and `hs_osc_en` is 0. Clearing `slow_sel` returns it to Normal.
- R3: `slow_sel` is ignored unless `hs_src`=0 and `lx_fitted`=1. With `hs_src`=1 (external crystal) or 2 (external RC), the mode stays 2'b00 and `sys_ce` follows `hs_tick`.
- R4: Source switching is glitch-free. Every `sys_ce` pulse coincides with a tick of an enabled source. Once the first pulse from the new source has appeared, no pulse from the old source follows.
- R5: With `FLEXIBLE`=0, `lx_osc_en` is 0 whenever `hs_src`≠0. With `FLEXIBLE`=1, the crystal stays enabled with any `hs_src` while `lx_fitted`=1.
- R6: A `halt_req` pulse in Normal or Slow enters Idle (`mode` 2'b10) if the crystal stays running, and Sleep (2'b11) otherwise. In both, `sys_ce` and `hs_osc_en` are 0.
- R7: With `FLEXIBLE`=0, `lx_keep` has no effect: a fitted crystal runs through halt, so the mode is Idle. With `FLEXIBLE`=1, `lx_keep`=0 gives Sleep with `lx_osc_en` 0, and `lx_keep`=1 gives Idle.
- R8: After `wake`, `sys_ce` stays 0 for `WAKE_CYCLES` cycles while `mode` already shows the return mode. The block then resumes the mode (Normal or Slow) that was active before the halt.
- R9: `wdt_src` selects the watchdog tick: 0 or 3 gives one `wdt_ce` per 4 `sys_ce` pulses, 1 gives `lirc_tick`, and 2 gives `lx_tick` while the crystal is enabled. `lirc_osc_en` is 1 only when `wdt_src`=1.
- R10: In Sleep, a watchdog on the internal low-speed RC keeps receiving its ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_src | input | 2 | High-speed source option: 0 internal RC, 1 external crystal, 2 external RC |
| lx_fitted | input | 1 | Option: low-speed crystal fitted |
| slow_sel | input | 1 | Mode-select bit: request Slow |
| lx_keep | input | 1 | Keep the crystal running during halt (flexible variant only) |
| wdt_src | input | 2 | Watchdog tick source option |
| halt_req | input | 1 | Halt request pulse |
| wake | input | 1 | Wake event |
| hs_tick | input | 1 | High-speed oscillator tick |
| lx_tick | input | 1 | Low-speed crystal tick |
| lirc_tick | input | 1 | Internal low-speed RC tick |
| sys_ce | output | 1 | Selected system clock enable |
| wdt_ce | output | 1 | Watchdog clock enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| lx_osc_en | output | 1 | Low-speed crystal enable |
| lirc_osc_en | output | 1 | Internal low-speed RC enable |
| mode | output | 2 | 00 Normal, 01 Slow, 10 Idle, 11 Sleep |

## Verification
The bench builds two copies side by side with `WAKE_CYCLES`=5 and identical stimulus: one with `FLEXIBLE`=0 and one with `FLEXIBLE`=1. A single halt with `lx_keep`=0 therefore shows Idle on one copy and Sleep on the other. A non-internal high-speed source shows the crystal dropped by one copy and kept by the other. The short wake count makes the exact silent window after a wake observable within a few cycles. The tick inputs are chosen so that `hs_tick` and `lx_tick` never coincide, which lets every system pulse be attributed to a single source.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_SLOW,
        ST_SWITCH,
        ST_IDLE,
        ST_SLEEP,
        ST_WAKE
    } pwr_state_e;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_SLOW   = 2'b01;
    localparam logic [1:0] MODE_IDLE   = 2'b10;
    localparam logic [1:0] MODE_SLEEP  = 2'b11;

    localparam logic [1:0] HS_INT_RC   = 2'd0;

    localparam logic [1:0] WDT_SYSDIV  = 2'd0;
    localparam logic [1:0] WDT_LIRC    = 2'd1;
    localparam logic [1:0] WDT_LXTAL   = 2'd2;

endpackage

// File: rtl/clk_src_policy.sv
module clk_src_policy
    import clk_pwr_pkg::*;
#(
    parameter bit FLEXIBLE = 1'b0
) (
    input  logic [1:0] hs_src,
    input  logic       lx_fitted,
    input  logic       lx_keep,
    output logic       lx_present,
    output logic       slow_ok,
    output logic       lx_halt_run
);

    logic on_int_rc;
    assign on_int_rc = (hs_src == HS_INT_RC);

    generate
        if (FLEXIBLE) begin : g_flex
            assign lx_present  = lx_fitted;
            assign lx_halt_run = lx_fitted & lx_keep;
        end else begin : g_restr
            // Crystal shares its pins with the external high-speed options.
            assign lx_present  = lx_fitted & on_int_rc;
            assign lx_halt_run = lx_fitted & on_int_rc;
        end
    endgenerate

    assign slow_ok = lx_present & on_int_rc;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import clk_pwr_pkg::*;
#(
    parameter int WAKE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_req,
    input  logic       lx_halt_run,
    input  logic       halt_req,
    input  logic       wake,
    input  logic       hs_tick,
    input  logic       lx_tick,
    output logic [1:0] mode_o,
    output logic       sys_ce_o,
    output logic       hs_en_o,
    output logic       in_sleep_o
);

    localparam int WCW = $clog2(WAKE_CYCLES + 1);
    localparam logic [WCW-1:0] WAKE_LAST = WCW'(WAKE_CYCLES - 1);

    pwr_state_e     state, state_nx;
    logic           slow_dest, dest_nx;
    logic [WCW-1:0] wake_cnt;
    logic           back_slow;

    assign back_slow = slow_dest & slow_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_NORMAL;
            slow_dest <= 1'b0;
            wake_cnt  <= '0;
        end else begin
            state     <= state_nx;
            slow_dest <= dest_nx;
            wake_cnt  <= (state == ST_WAKE) ? wake_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        dest_nx  = slow_dest;
        unique case (state)
            ST_NORMAL: begin
                if (halt_req) begin
                    state_nx = lx_halt_run ? ST_IDLE : ST_SLEEP;
                    dest_nx  = 1'b0;
                end else if (slow_req) begin
                    state_nx = ST_SWITCH;
                    dest_nx  = 1'b1;
                end
            end
            ST_SLOW: begin
                if (halt_req) begin
                    state_nx = lx_halt_run ? ST_IDLE : ST_SLEEP;
                    dest_nx  = 1'b1;
                end else if (!slow_req) begin
                    state_nx = ST_SWITCH;
                    dest_nx  = 1'b0;
                end
            end
            ST_SWITCH: begin
                if (slow_dest && !slow_req) begin
                    dest_nx = 1'b0;
                end else if (slow_dest ? lx_tick : hs_tick) begin
                    state_nx = slow_dest ? ST_SLOW : ST_NORMAL;
                end
            end
            ST_IDLE, ST_SLEEP: begin
                if (wake) state_nx = ST_WAKE;
            end
            ST_WAKE: begin
                if (wake_cnt == WAKE_LAST) state_nx = back_slow ? ST_SLOW : ST_NORMAL;
            end
            default: state_nx = ST_NORMAL;
        endcase
    end

    always_comb begin
        mode_o     = MODE_NORMAL;
        sys_ce_o   = 1'b0;
        hs_en_o    = 1'b0;
        in_sleep_o = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                sys_ce_o = hs_tick;
                hs_en_o  = 1'b1;
            end
            ST_SLOW: begin
                mode_o   = MODE_SLOW;
                sys_ce_o = lx_tick & slow_req;
            end
            ST_SWITCH: begin
                mode_o  = slow_dest ? MODE_SLOW : MODE_NORMAL;
                hs_en_o = !slow_dest;
            end
            ST_IDLE:  mode_o = MODE_IDLE;
            ST_SLEEP: begin
                mode_o     = MODE_SLEEP;
                in_sleep_o = 1'b1;
            end
            ST_WAKE: begin
                mode_o  = back_slow ? MODE_SLOW : MODE_NORMAL;
                hs_en_o = !back_slow;
            end
            default: mode_o = MODE_NORMAL;
        endcase
    end

    // R8: a halted controller stays halted until a wake event
    assert_halt_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_SLEEP) && !wake) |=> (state == $past(state)));

    // R6: halt is entered only from a settled run mode
    assert_halt_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_SLEEP) && $past(state) != state)
            |-> ($past(state) == ST_NORMAL || $past(state) == ST_SLOW));

endmodule

// File: rtl/wdt_clk_sel.sv
module wdt_clk_sel
    import clk_pwr_pkg::*;
#(
    parameter int WDT_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       sys_ce,
    input  logic       lirc_tick,
    input  logic       lx_tick,
    input  logic       lx_en,
    output logic       wdt_ce,
    output logic       lirc_en
);

    localparam int DW = (WDT_DIV > 1) ? $clog2(WDT_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(WDT_DIV - 1);

    logic [DW-1:0] div_cnt;
    logic          div_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (sys_ce) begin
            div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
        end
    end

    assign div_pulse = sys_ce & (div_cnt == DIV_LAST);
    assign lirc_en   = (sel == WDT_LIRC);

    always_comb begin
        unique case (sel)
            WDT_LIRC:  wdt_ce = lirc_tick & lirc_en;
            WDT_LXTAL: wdt_ce = lx_tick & lx_en;
            default:   wdt_ce = div_pulse;
        endcase
    end

    // R9: a divided watchdog tick only falls on a system tick
    assert_div_on_sys_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ce && (sel == WDT_SYSDIV || sel == 2'd3)) |-> sys_ce);

endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
    import clk_pwr_pkg::*;
#(
    parameter bit FLEXIBLE    = 1'b0,
    parameter int WAKE_CYCLES = 16,
    parameter int WDT_DIV     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hs_src,
    input  logic       lx_fitted,
    input  logic       slow_sel,
    input  logic       lx_keep,
    input  logic [1:0] wdt_src,
    input  logic       halt_req,
    input  logic       wake,
    input  logic       hs_tick,
    input  logic       lx_tick,
    input  logic       lirc_tick,
    output logic       sys_ce,
    output logic       wdt_ce,
    output logic       hs_osc_en,
    output logic       lx_osc_en,
    output logic       lirc_osc_en,
    output logic [1:0] mode
);

    logic lx_present, slow_ok, lx_halt_run, in_sleep;

    clk_src_policy #(.FLEXIBLE(FLEXIBLE)) u_policy (
        .hs_src     (hs_src),
        .lx_fitted  (lx_fitted),
        .lx_keep    (lx_keep),
        .lx_present (lx_present),
        .slow_ok    (slow_ok),
        .lx_halt_run(lx_halt_run)
    );

    pwr_mode_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_req   (slow_sel & slow_ok),
        .lx_halt_run(lx_halt_run),
        .halt_req   (halt_req),
        .wake       (wake),
        .hs_tick    (hs_tick),
        .lx_tick    (lx_tick),
        .mode_o     (mode),
        .sys_ce_o   (sys_ce),
        .hs_en_o    (hs_osc_en),
        .in_sleep_o (in_sleep)
    );

    assign lx_osc_en = lx_present & !in_sleep;

    wdt_clk_sel #(.WDT_DIV(WDT_DIV)) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (wdt_src),
        .sys_ce   (sys_ce),
        .lirc_tick(lirc_tick),
        .lx_tick  (lx_tick),
        .lx_en    (lx_osc_en),
        .wdt_ce   (wdt_ce),
        .lirc_en  (lirc_osc_en)
    );

    // R4: every system tick comes from an enabled source
    assert_ce_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ce |-> ((hs_tick && hs_osc_en) || (lx_tick && lx_osc_en)));

    // R6: halted modes carry no system tick and no high-speed oscillator
    assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (!sys_ce && !hs_osc_en));

    // R5: restricted variant never runs the crystal beside an external source
    assert_restricted_lx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!FLEXIBLE && hs_src != HS_INT_RC) |-> !lx_osc_en);

    // R7: Sleep always has the crystal stopped
    assert_sleep_lx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP) |-> !lx_osc_en);

endmodule

// File: tb/clk_pwr_ctrl_bench.sv
module clk_pwr_ctrl_bench;

    localparam int WAKE_N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] hs_src = 2'd0;
    logic       lx_fitted = 1'b1;
    logic       slow_sel = 1'b0;
    logic       lx_keep = 1'b0;
    logic [1:0] wdt_src = 2'd0;
    logic       halt_req = 1'b0;
    logic       wake = 1'b0;
    logic       hs_tick = 1'b0;
    logic       lx_tick = 1'b0;
    logic       lirc_tick = 1'b0;
    logic [7:0] tcnt = '0;

    logic       r_sys, r_wdt, r_hs, r_lx, r_lirc;
    logic [1:0] r_mode;
    logic       f_sys, f_wdt, f_hs, f_lx, f_lirc;
    logic [1:0] f_mode;

    int n_chk = 0;
    int n_bad = 0;
    int c_hs, c_lx, c_lirc, c_rsys, c_fsys, c_rwdt, c_fwdt;

    always #5 clk = ~clk;

    // free-running oscillator ticks; hs and lx never coincide
    always @(posedge clk) begin
        tcnt      <= tcnt + 8'd1;
        hs_tick   <= tcnt[0];
        lx_tick   <= (tcnt[2:0] == 3'd2);
        lirc_tick <= ((tcnt % 8'd6) == 8'd1);
    end

    clk_pwr_ctrl #(.FLEXIBLE(1'b0), .WAKE_CYCLES(WAKE_N), .WDT_DIV(4)) u_clk_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .hs_src(hs_src), .lx_fitted(lx_fitted),
        .slow_sel(slow_sel), .lx_keep(lx_keep), .wdt_src(wdt_src),
        .halt_req(halt_req), .wake(wake), .hs_tick(hs_tick), .lx_tick(lx_tick),
        .lirc_tick(lirc_tick), .sys_ce(r_sys), .wdt_ce(r_wdt), .hs_osc_en(r_hs),
        .lx_osc_en(r_lx), .lirc_osc_en(r_lirc), .mode(r_mode)
    );

    clk_pwr_ctrl #(.FLEXIBLE(1'b1), .WAKE_CYCLES(WAKE_N), .WDT_DIV(4)) u_clk_pwr_ctrl_flex (
        .clk(clk), .rst_n(rst_n), .hs_src(hs_src), .lx_fitted(lx_fitted),
        .slow_sel(slow_sel), .lx_keep(lx_keep), .wdt_src(wdt_src),
        .halt_req(halt_req), .wake(wake), .hs_tick(hs_tick), .lx_tick(lx_tick),
        .lirc_tick(lirc_tick), .sys_ce(f_sys), .wdt_ce(f_wdt), .hs_osc_en(f_hs),
        .lx_osc_en(f_lx), .lirc_osc_en(f_lirc), .mode(f_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n);
        c_hs = 0; c_lx = 0; c_lirc = 0; c_rsys = 0; c_fsys = 0; c_rwdt = 0; c_fwdt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c_hs   += int'(hs_tick);
            c_lx   += int'(lx_tick);
            c_lirc += int'(lirc_tick);
            c_rsys += int'(r_sys);
            c_fsys += int'(f_sys);
            c_rwdt += int'(r_wdt);
            c_fwdt += int'(f_wdt);
        end
    endtask

    task automatic pulse_halt();
        @(negedge clk); halt_req = 1'b1;
        @(negedge clk); halt_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "restricted mode after reset", int'(r_mode), 0);
        chk("R1", "flexible mode after reset", int'(f_mode), 0);
        chk("R1", "hs enable after reset", int'(r_hs), 1);
    endtask

    task automatic t_normal();
        measure(40);
        chk("R1", "normal sys ticks restricted", c_rsys, c_hs);
        chk("R1", "normal sys ticks flexible", c_fsys, c_hs);
    endtask

    task automatic t_cfg_block();
        hs_src = 2'd1; slow_sel = 1'b1;
        idle(20);
        chk("R3", "mode with external crystal source", int'(r_mode), 0);
        chk("R3", "flex mode with external crystal source", int'(f_mode), 0);
        chk("R5", "restricted crystal enable", int'(r_lx), 0);
        chk("R5", "flexible crystal enable", int'(f_lx), 1);
        measure(32);
        chk("R3", "sys follows hs while slow ignored", c_rsys, c_hs);
        hs_src = 2'd2;
        idle(4);
        chk("R3", "mode with external RC source", int'(f_mode), 0);
        chk("R5", "restricted crystal with external RC", int'(r_lx), 0);
        slow_sel = 1'b0; hs_src = 2'd0;
        idle(4);
    endtask

    task automatic t_switch_slow();
        int bad_r = 0, bad_f = 0;
        bit seen_r = 0, seen_f = 0;
        slow_sel = 1'b1;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (r_sys && !(hs_tick || lx_tick)) bad_r++;
            if (f_sys && !(hs_tick || lx_tick)) bad_f++;
            if (r_sys && lx_tick) seen_r = 1;
            if (f_sys && lx_tick) seen_f = 1;
            if (r_sys && hs_tick && seen_r) bad_r++;
            if (f_sys && hs_tick && seen_f) bad_f++;
        end
        chk("R4", "glitches during switch restricted", bad_r, 0);
        chk("R4", "glitches during switch flexible", bad_f, 0);
        chk("R2", "mode after slow switch", int'(r_mode), 1);
        chk("R2", "hs enable in slow", int'(r_hs), 0);
        measure(48);
        chk("R2", "slow sys ticks restricted", c_rsys, c_lx);
        chk("R2", "slow sys ticks flexible", c_fsys, c_lx);
    endtask

    task automatic t_halt_from_slow();
        lx_keep = 1'b0;
        pulse_halt();
        idle(2);
        chk("R7", "restricted ignores keep, halts to idle", int'(r_mode), 2);
        chk("R7", "flexible keep=0 halts to sleep", int'(f_mode), 3);
        chk("R7", "flexible crystal off in sleep", int'(f_lx), 0);
        chk("R7", "restricted crystal on in idle", int'(r_lx), 1);
        chk("R6", "hs enable in idle", int'(r_hs), 0);
        measure(24);
        chk("R6", "sys ticks while halted restricted", c_rsys, 0);
        chk("R6", "sys ticks while halted flexible", c_fsys, 0);
    endtask

    task automatic t_wake(input int exp_mode, input int resume_win);
        int quiet = 0, resumed = 0;
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        chk("R8", "mode during wake shows return mode", int'(f_mode), exp_mode);
        for (int i = 0; i < WAKE_N; i++) begin
            if (i > 0) @(negedge clk);
            quiet += int'(r_sys) + int'(f_sys);
        end
        chk("R8", "sys ticks inside wake window", quiet, 0);
        for (int i = 0; i < resume_win; i++) begin
            @(negedge clk);
            resumed += int'(f_sys);
        end
        chk("R8", "sys resumes after wake", int'(resumed > 0), 1);
        chk("R8", "mode after wake restricted", int'(r_mode), exp_mode);
        chk("R8", "mode after wake flexible", int'(f_mode), exp_mode);
    endtask

    task automatic t_back_normal();
        slow_sel = 1'b0;
        idle(12);
        chk("R2", "mode after clearing slow select", int'(r_mode), 0);
        measure(40);
        chk("R2", "normal ticks after leaving slow", c_rsys, c_hs);
    endtask

    task automatic t_halt_keep();
        lx_keep = 1'b1;
        pulse_halt();
        idle(2);
        chk("R7", "flexible keep=1 halts to idle", int'(f_mode), 2);
        chk("R7", "flexible crystal kept in idle", int'(f_lx), 1);
        chk("R6", "hs enable in flexible idle", int'(f_hs), 0);
        t_wake(0, 4);
        lx_keep = 1'b0;
    endtask

    task automatic t_wdt();
        wdt_src = 2'd0;
        idle(2);
        chk("R9", "lirc enable off for divided source", int'(r_lirc), 0);
        measure(40);
        chk("R9", "divided watchdog ticks", c_rwdt, c_rsys / 4);
        wdt_src = 2'd3;
        measure(40);
        chk("R9", "code 3 as divided source", c_fwdt, c_fsys / 4);
        wdt_src = 2'd1;
        idle(2);
        chk("R9", "lirc enable when selected", int'(r_lirc), 1);
        measure(36);
        chk("R9", "lirc watchdog ticks", c_rwdt, c_lirc);
        wdt_src = 2'd2;
        measure(40);
        chk("R9", "crystal watchdog ticks", c_fwdt, c_lx);
    endtask

    task automatic t_wdt_sleep();
        wdt_src = 2'd1; lx_keep = 1'b0;
        pulse_halt();
        idle(2);
        chk("R10", "flexible in sleep", int'(f_mode), 3);
        chk("R10", "lirc enable in sleep", int'(f_lirc), 1);
        measure(36);
        chk("R10", "watchdog ticks in sleep", c_fwdt, c_lirc);
        t_wake(0, 4);
        wdt_src = 2'd0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_cfg_block();
        t_switch_slow();
        t_halt_from_slow();
        t_wake(1, 10);
        t_back_normal();
        t_halt_keep();
        t_wdt();
        t_wdt_sleep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule